// File: doc/BRIEF.md
# Storage Controller PCI Configuration Register File

This block holds the function-0 configuration header of a disk controller. A static strap selects its identity: a plain IDE function or a RAID-class function. A synchronous byte port carries single-byte reads and writes. Each register applies its own write rule:

- a bit mask on the value written;
- write-one-to-clear bits;
- a write that only takes effect while a condition holds;
- a status bit that clears when the register is read.

The four I/O base address registers accept writes only while a lock bit in a vendor register is set. The RAID strap forces that lock bit open.

The block also keeps an optional expansion-ROM base register, which decodes a 16 KB window. It drives the decoded BAR bases, the I/O and memory enables and the ROM window to the rest of the controller. A combinational `rom_hit` flags memory addresses that fall inside the enabled window. Software on the host configures the function through the port, and the data path uses the decoded outputs.

Top module: `stor_cfg_space`

## Requirements
- R1: After reset the registers hold: 0x04 = 0x00, 0x06 = 0x80, 0x07 = 0x02, 0x0B = 0x01. In IDE mode, 0x0A = 0x01, 0x09 = the strap value and 0x50 = 0x00. In RAID mode, 0x0A = 0x04, 0x09 = 0x00 and 0x50 = 0x40.
- R2: A write to 0x04 stores the data ANDed with 0x47 when a ROM is fitted, or with 0x45 when none is fitted. Bit 0 drives `io_en` and bit 1 drives `mem_en`.
- R3: At 0x07, writing a 1 to a bit in mask 0xB1 clears that bit. Other bits, including bit 1, are unchanged by writes, and a write never sets a bit.
- R4: In IDE mode a BAR byte write (0x10/0x11, 0x14/0x15, 0x18/0x19, 0x1C/0x1D) is ignored unless bit 6 of 0x50 is set. Register 0x50 is fully writable.
- R5: A BAR low byte stores the data ANDed with 0xF8 at 0x10 and 0x18, and with 0xFC at 0x14 and 0x1C. Its bit 0 always reads 1, and high bytes store the data unchanged. `bar_base[n]` is {high byte, low byte with bit 0 cleared}.
- R6: In RAID mode the BAR write gate is always open, and a read of 0x09 returns 0x00.
- R7: A read of 0x50 returns the stored value and then clears bit 2. A read of 0x57 returns the stored value and then clears bit 4. Register 0x57 is fully writable.
- R8: In IDE mode a write to 0x09 is accepted only while bits 1 and 3 of 0x09 are both set. The new value is (old AND 0x8A) OR (data AND 0x05).
- R9: With a ROM fitted, bytes 0x30 to 0x33 form a little-endian 32-bit register that is stored ANDed with 0xFFFFC001. Without a ROM, the register stays 0.
- R10: The ROM window is enabled only when 0x04 bit 1 and 0x30 bit 0 are both set. `rom_hit` is high when the window is enabled and `mem_addr[31:14]` equals the stored base bits 31:14.
- R11: Read data appears on `cfg_rdata` one cycle after `cfg_rd` and holds until the next read. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Byte write strobe |
| cfg_rd | input | 1 | Byte read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| mem_addr | input | 32 | Memory address tested against the ROM window |
| io_en | output | 1 | Command bit 0 |
| mem_en | output | 1 | Command bit 1 |
| bar_base | output | 64 | Four 16-bit I/O BAR bases, BAR 0 in the low bits |
| rom_base | output | 32 | Aligned ROM base |
| rom_win_en | output | 1 | ROM window enabled |
| rom_hit | output | 1 | Address falls in the enabled ROM window |

## Verification
A wrong mask or a lost write-one-to-clear shows on `cfg_rdata` one cycle after the next read of that offset. A BAR gate that opens wrongly shows at once on `bar_base`. A read-clear that fires early returns the cleared value in place of the stored one. A read-clear that never fires shows on the second read. A wrong enable condition on the ROM window shows combinationally on `rom_hit` in the same cycle that `mem_addr` is driven.

// File: rtl/stor_cfg_pkg.sv
package stor_cfg_pkg;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_STLO  = 8'h06;
  localparam logic [7:0] OFS_STHI  = 8'h07;
  localparam logic [7:0] OFS_PIF   = 8'h09;
  localparam logic [7:0] OFS_SUB   = 8'h0A;
  localparam logic [7:0] OFS_BASE  = 8'h0B;
  localparam logic [7:0] OFS_LOCK  = 8'h50;
  localparam logic [7:0] OFS_AUX   = 8'h57;
  localparam logic [3:0] BAR_ROW   = 4'h1;
  localparam logic [5:0] ROM_ROW   = 6'b001100;

  localparam logic [7:0] CMD_KEEP_ROM   = 8'h47;
  localparam logic [7:0] CMD_KEEP_NOROM = 8'h45;
  localparam logic [7:0] STAT_W1C       = 8'hB1;
  localparam logic [7:0] STAT_RESET     = 8'h02;
  localparam logic [7:0] STLO_VALUE     = 8'h80;
  localparam logic [7:0] PIF_HOLD       = 8'h8A;
  localparam logic [7:0] PIF_TAKE       = 8'h05;
  localparam logic [7:0] PIF_GATE       = 8'h0A;
  localparam int         LOCK_BIT       = 6;
  localparam int         LOCK_RDCLR_BIT = 2;
  localparam int         AUX_RDCLR_BIT  = 4;

  function automatic logic [7:0] bar_lo_keep(input int idx);
    return (idx % 2 == 1) ? 8'hFC : 8'hF8;
  endfunction
endpackage

// File: rtl/stor_cfg_bar.sv
module stor_cfg_bar #(
  parameter logic [7:0] LO_KEEP = 8'hF8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we_lo,
  input  logic       we_hi,
  input  logic [7:0] wd,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 8'h01;
      hi_q <= 8'h00;
    end else begin
      if (we_lo) lo_q <= (wd & LO_KEEP) | 8'h01;
      if (we_hi) hi_q <= wd;
    end
  end

  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!we_lo && !we_hi) |=> $stable({lo_q, hi_q})); // R4
endmodule

// File: rtl/stor_cfg_rom.sv
module stor_cfg_rom #(
  parameter int REG_W    = 32,
  parameter int WIN_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W/8-1:0] we,
  input  logic [7:0]       wd,
  input  logic             mem_en,
  input  logic [REG_W-1:0] mem_addr,
  output logic [REG_W-1:0] rom_q,
  output logic             win_en,
  output logic             hit
);
  localparam int NBYTE = REG_W / 8;
  localparam logic [REG_W-1:0] KEEP =
    ~((REG_W'(1) << WIN_LOG2) - REG_W'(1)) | REG_W'(1);

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) rom_q[8*b +: 8] <= 8'h00;
      else if (we[b]) rom_q[8*b +: 8] <= wd & KEEP[8*b +: 8];
    end
  end

  assign win_en = mem_en && rom_q[0];
  assign hit    = win_en && (mem_addr[REG_W-1:WIN_LOG2] == rom_q[REG_W-1:WIN_LOG2]);

  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (we == '0) |=> $stable(rom_q)); // R9
endmodule

// File: rtl/stor_cfg_space.sv
module stor_cfg_space
  import stor_cfg_pkg::*;
#(
  parameter bit         ROM_FITTED = 1'b1,
  parameter bit         RAID_STRAP = 1'b0,
  parameter logic [7:0] PIF_STRAP  = 8'h8A,
  parameter int         NBAR       = 4,
  parameter int         BAR_W      = 16,
  parameter int         ROM_W      = 32,
  parameter int         WIN_LOG2   = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic                      cfg_rd,
  input  logic [7:0]                cfg_addr,
  input  logic [7:0]                cfg_wdata,
  output logic [7:0]                cfg_rdata,
  input  logic [ROM_W-1:0]          mem_addr,
  output logic                      io_en,
  output logic                      mem_en,
  output logic [NBAR-1:0][BAR_W-1:0] bar_base,
  output logic [ROM_W-1:0]          rom_base,
  output logic                      rom_win_en,
  output logic                      rom_hit
);
  localparam logic [7:0] CMD_KEEP  = ROM_FITTED ? CMD_KEEP_ROM : CMD_KEEP_NOROM;
  localparam logic [7:0] SUB_VAL   = RAID_STRAP ? 8'h04 : 8'h01;
  localparam logic [7:0] PIF_RST   = RAID_STRAP ? 8'h00 : PIF_STRAP;
  localparam logic [7:0] LOCK_RST  = RAID_STRAP ? 8'h40 : 8'h00;
  localparam int         ROM_BYTES = ROM_W / 8;

  logic [7:0] cmd_q, sthi_q, pif_q, lock_q, aux_q;
  logic [NBAR-1:0][7:0] bar_lo, bar_hi;
  logic [ROM_W-1:0] rom_q;
  logic [ROM_BYTES-1:0] rom_we;
  logic bar_gate;
  logic [7:0] rd_mux;

  function automatic logic hit_at(input logic [7:0] ofs);
    return cfg_wr && (cfg_addr == ofs);
  endfunction

  assign bar_gate = RAID_STRAP || lock_q[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 8'h00;
      sthi_q <= STAT_RESET;
      pif_q  <= PIF_RST;
      lock_q <= LOCK_RST;
      aux_q  <= 8'h00;
    end else begin
      if (hit_at(OFS_CMD))  cmd_q  <= cfg_wdata & CMD_KEEP;
      if (hit_at(OFS_STHI)) sthi_q <= sthi_q & ~(cfg_wdata & STAT_W1C);
      if (hit_at(OFS_PIF) && !RAID_STRAP && ((pif_q & PIF_GATE) == PIF_GATE))
        pif_q <= (pif_q & PIF_HOLD) | (cfg_wdata & PIF_TAKE);
      if (hit_at(OFS_LOCK)) lock_q <= cfg_wdata;
      else if (cfg_rd && cfg_addr == OFS_LOCK) lock_q[LOCK_RDCLR_BIT] <= 1'b0;
      if (hit_at(OFS_AUX)) aux_q <= cfg_wdata;
      else if (cfg_rd && cfg_addr == OFS_AUX) aux_q[AUX_RDCLR_BIT] <= 1'b0;
    end
  end

  for (genvar i = 0; i < NBAR; i++) begin : g_bar
    logic we_lo, we_hi;
    assign we_lo = cfg_wr && bar_gate && (cfg_addr == {BAR_ROW, 4'(i * 4)});
    assign we_hi = cfg_wr && bar_gate && (cfg_addr == {BAR_ROW, 4'(i * 4 + 1)});
    stor_cfg_bar #(.LO_KEEP(bar_lo_keep(i))) u_bar (
      .clk(clk), .rst(rst), .we_lo(we_lo), .we_hi(we_hi), .wd(cfg_wdata),
      .lo_q(bar_lo[i]), .hi_q(bar_hi[i])
    );
    assign bar_base[i] = BAR_W'({bar_hi[i], bar_lo[i][7:1], 1'b0});
  end

  for (genvar b = 0; b < ROM_BYTES; b++) begin : g_romwe
    assign rom_we[b] = ROM_FITTED && cfg_wr && (cfg_addr == {ROM_ROW, 2'(b)});
  end

  stor_cfg_rom #(.REG_W(ROM_W), .WIN_LOG2(WIN_LOG2)) u_rom (
    .clk(clk), .rst(rst), .we(rom_we), .wd(cfg_wdata), .mem_en(cmd_q[1]),
    .mem_addr(mem_addr), .rom_q(rom_q), .win_en(rom_win_en), .hit(rom_hit)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (cfg_addr)
      OFS_CMD:  rd_mux = cmd_q;
      OFS_STLO: rd_mux = STLO_VALUE;
      OFS_STHI: rd_mux = sthi_q;
      OFS_PIF:  rd_mux = RAID_STRAP ? 8'h00 : pif_q;
      OFS_SUB:  rd_mux = SUB_VAL;
      OFS_BASE: rd_mux = 8'h01;
      OFS_LOCK: rd_mux = lock_q;
      OFS_AUX:  rd_mux = aux_q;
      default: begin
        if (cfg_addr[7:4] == BAR_ROW && int'(cfg_addr[3:2]) < NBAR) begin
          if (cfg_addr[1:0] == 2'd0)      rd_mux = bar_lo[cfg_addr[3:2]];
          else if (cfg_addr[1:0] == 2'd1) rd_mux = bar_hi[cfg_addr[3:2]];
        end else if (cfg_addr[7:2] == ROM_ROW) begin
          rd_mux = rom_q[8*cfg_addr[1:0] +: 8];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= 8'h00;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign io_en    = cmd_q[0];
  assign mem_en   = cmd_q[1];
  assign rom_base = {rom_q[ROM_W-1:WIN_LOG2], WIN_LOG2'(0)};

  AST_STAT_NOSET: assert property (@(posedge clk) disable iff (rst)
    hit_at(OFS_STHI) |=> ((sthi_q & ~$past(sthi_q)) == 8'h00)); // R3
  AST_LOCK_RDCLR: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !cfg_wr && cfg_addr == OFS_LOCK) |=> !lock_q[LOCK_RDCLR_BIT]); // R7
  AST_ROM_HIT_GATE: assert property (@(posedge clk) disable iff (rst)
    rom_hit |-> (mem_en && rom_base[WIN_LOG2-1:0] == '0)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(cfg_rdata)); // R11
  if (RAID_STRAP) begin : g_raid_chk
    AST_PIF_ZERO: assert property (@(posedge clk) disable iff (rst)
      (cfg_rd && cfg_addr == OFS_PIF) |=> (cfg_rdata == 8'h00)); // R6
  end
endmodule

// File: tb/sim_stor_cfg_space.sv
module sim_stor_cfg_space;
  localparam int CLK_P = 10;
  localparam int NV = 45;

  logic clk = 1'b0, rst = 1'b1;
  logic wr0 = 0, rd0 = 0, wr1 = 0, rd1 = 0;
  logic [7:0] addr = 0, wdat = 0;
  logic [31:0] maddr = 0;
  logic [7:0] rdat0, rdat1;
  logic io0, mem0, win0, hit0, io1, mem1, win1, hit1;
  logic [3:0][15:0] bars0, bars1;
  logic [31:0] rb0, rb1;
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  stor_cfg_space u0 (
    .clk(clk), .rst(rst), .cfg_wr(wr0), .cfg_rd(rd0), .cfg_addr(addr),
    .cfg_wdata(wdat), .cfg_rdata(rdat0), .mem_addr(maddr), .io_en(io0),
    .mem_en(mem0), .bar_base(bars0), .rom_base(rb0), .rom_win_en(win0),
    .rom_hit(hit0));

  stor_cfg_space #(.RAID_STRAP(1'b1)) u1 (
    .clk(clk), .rst(rst), .cfg_wr(wr1), .cfg_rd(rd1), .cfg_addr(addr),
    .cfg_wdata(wdat), .cfg_rdata(rdat1), .mem_addr(maddr), .io_en(io1),
    .mem_en(mem1), .bar_base(bars1), .rom_base(rb1), .rom_win_en(win1),
    .rom_hit(hit1));

  // {read, offset, data-or-expected}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h04, 8'h00}, {1'b1, 8'h06, 8'h80}, {1'b1, 8'h07, 8'h02},   // R1
    {1'b1, 8'h09, 8'h8A}, {1'b1, 8'h0A, 8'h01}, {1'b1, 8'h0B, 8'h01},   // R1
    {1'b1, 8'h50, 8'h00},                                               // R1
    {1'b0, 8'h04, 8'hFF}, {1'b1, 8'h04, 8'h47},                         // R2
    {1'b0, 8'h07, 8'hFF}, {1'b1, 8'h07, 8'h02},                         // R3
    {1'b0, 8'h10, 8'hFF}, {1'b1, 8'h10, 8'h01},                         // R4
    {1'b0, 8'h11, 8'hAB}, {1'b1, 8'h11, 8'h00},                         // R4
    {1'b0, 8'h50, 8'h44}, {1'b1, 8'h50, 8'h44}, {1'b1, 8'h50, 8'h40},   // R7
    {1'b0, 8'h10, 8'hFF}, {1'b1, 8'h10, 8'hF9},                         // R5
    {1'b0, 8'h11, 8'hAB}, {1'b1, 8'h11, 8'hAB},                         // R5
    {1'b0, 8'h14, 8'hFF}, {1'b1, 8'h14, 8'hFD},                         // R5
    {1'b0, 8'h18, 8'h00}, {1'b1, 8'h18, 8'h01},                         // R5
    {1'b0, 8'h1C, 8'h5A}, {1'b1, 8'h1C, 8'h59},                         // R5
    {1'b0, 8'h57, 8'hFF}, {1'b1, 8'h57, 8'hFF}, {1'b1, 8'h57, 8'hEF},   // R7
    {1'b0, 8'h09, 8'hFF}, {1'b1, 8'h09, 8'h8F},                         // R8
    {1'b0, 8'h09, 8'h00}, {1'b1, 8'h09, 8'h8A},                         // R8
    {1'b0, 8'h30, 8'hFF}, {1'b0, 8'h31, 8'hFF},                         // R9
    {1'b0, 8'h32, 8'h12}, {1'b0, 8'h33, 8'h34},                         // R9
    {1'b1, 8'h30, 8'h01}, {1'b1, 8'h31, 8'hC0},                         // R9
    {1'b1, 8'h32, 8'h12}, {1'b1, 8'h33, 8'h34},                         // R9
    {1'b1, 8'h40, 8'h00}, {1'b1, 8'h12, 8'h00}                          // R11
  };
  localparam int VREQ [NV] = '{1,1,1,1,1,1,1, 2,2, 3,3, 4,4,4,4, 7,7,7,
    5,5,5,5,5,5,5,5,5,5, 7,7,7, 8,8,8,8, 9,9,9,9,9,9,9,9, 11,11};

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input int inst, input bit is_rd, input logic [7:0] a,
                      input logic [7:0] d, input int req);
    @(negedge clk);
    addr = a; wdat = d;
    if (inst == 0) begin wr0 = !is_rd; rd0 = is_rd; end
    else           begin wr1 = !is_rd; rd1 = is_rd; end
    @(negedge clk);
    wr0 = 0; rd0 = 0; wr1 = 0; rd1 = 0;
    if (is_rd) check({24'h0, (inst == 0) ? rdat0 : rdat1}, {24'h0, d}, req);
  endtask

  initial begin
    #(CLK_P * 50000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({31'h0, hit0}, 32'h0, 10);               // R10 no hit after reset
    for (int i = 0; i < NV; i++)
      xfer(0, VEC[i][16], VEC[i][15:8], VEC[i][7:0], VREQ[i]);

    check({16'h0, bars0[0]}, 32'h0000ABF8, 5);     // R5 decoded base
    check({30'h0, mem0, io0}, 32'h3, 2);           // R2 enables
    check(rb0, 32'h3412C000, 9);                   // R9 aligned base
    maddr = 32'h3412C123; #1;
    check({31'h0, hit0}, 32'h1, 10);               // R10 inside window
    maddr = 32'h34130000; #1;
    check({31'h0, hit0}, 32'h0, 10);               // R10 next window
    maddr = 32'h3412FFFF;
    xfer(0, 1'b0, 8'h04, 8'h05, 10);
    check({31'h0, hit0}, 32'h0, 10);               // R10 memory disabled
    xfer(0, 1'b0, 8'h04, 8'h47, 10);
    check({31'h0, hit0}, 32'h1, 10);               // R10 re-enabled
    xfer(0, 1'b0, 8'h30, 8'h00, 10);
    check({30'h0, win0, hit0}, 32'h0, 10);         // R10 ROM bit off

    xfer(0, 1'b1, 8'h06, 8'h80, 11);               // R11 one-cycle latency
    @(negedge clk);
    check({24'h0, rdat0}, 32'h80, 11);             // R11 held while idle

    xfer(1, 1'b1, 8'h09, 8'h00, 6);                // R6 pif reads zero
    xfer(1, 1'b1, 8'h0A, 8'h04, 1);                // R1 RAID subclass
    xfer(1, 1'b1, 8'h50, 8'h40, 1);                // R1 RAID lock reset
    xfer(1, 1'b0, 8'h50, 8'h00, 6);
    xfer(1, 1'b0, 8'h10, 8'hFF, 6);
    xfer(1, 1'b1, 8'h10, 8'hF9, 6);                // R6 gate forced open
    xfer(1, 1'b0, 8'h1D, 8'hC3, 6);
    check({16'h0, bars1[3]}, 32'h0000C300, 6);     // R6 high byte accepted

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule